// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between a 16-bit CPU address bus and the chip's memory resources. Each access is decoded in the same cycle into exactly one resource select: the on-chip control register block, the normal vector area, a debug ROM, debug registers, RAM, EEPROM, flash, one of three paging windows, or the external unpaged bus. When an access lands in a paging window, the block forms a wider physical address by placing that window's 8-bit page value above the offset within the window. A window shows one page at a time. Software selects a different page by writing that window's page register.

The page registers and the base registers of the four relocatable on-chip regions live inside the register block. They are written with ordinary bus writes. Regions may overlap after relocation, and a fixed precedence then picks one winner. A debug input overlays a debug ROM and debug registers on the top of memory. These appear only while the input is high. The memory arrays, bus timing and any call/return page handling are outside this block.

Top module: `mmap_decoder`

## Requirements
- R1: While `cpu_valid` is high, exactly one of `sel_o` and `ext_o` is set. While it is low, all of them are zero. The `sel_o` bits are: 0 register block, 1 vectors, 2 debug ROM, 3 debug registers, 4 RAM, 5 EEPROM, 6 flash, 7 program window, 8 data window, 9 extra window.
- R2: When several resources match, the lowest-numbered `sel_o` bit wins. Precedence from highest to lowest is: register block, then vectors / debug ROM / debug registers, then RAM, EEPROM, flash, and finally the windows.
- R3: The program window covers $8000–$BFFF, the data window $7000–$7FFF and the extra window $0400–$07FF. In a window, `phys_o` is {page, address bits below the window size}, zero-extended to 22 bits.
- R4: The page registers sit at register-block offsets $10 (program), $11 (data) and $12 (extra). They reset to zero. A write changes the page seen from the next access onward.
- R5: An address in $C000–$FFFF never selects a window, and its `phys_o` equals the CPU address.
- R6: While `dbg_active` is high, $FF20–$FFFF selects the debug ROM, which replaces the vectors, and $FF00–$FF06 selects the debug registers.
- R7: While `dbg_active` is low, the debug resources never appear. In that state $FFC0–$FFFF selects the vectors, and $FF00–$FFBF decodes as it otherwise would.
- R8: The base registers hold the upper address byte of each region. They sit at offsets $18 (register block, 512 B), $19 (RAM, 1 KB), $1A (EEPROM, 768 B) and $1B (flash, 16 KB). Their reset values are $00, $08, $10 and $C0. A region covers base to base+size−1, capped at $FFFF.
- R9: An address that matches nothing goes to the external bus (`ext_o`), with `phys_o` equal to the CPU address.
- R10: A write changes a page or base register only when the register block wins the decode. A write to any other resource leaves all of them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Access strobe |
| cpu_wr | input | 1 | Write access |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Write data |
| dbg_active | input | 1 | Debug mode active |
| sel_o | output | 10 | One-hot resource select |
| ext_o | output | 1 | External unpaged access |
| phys_o | output | 22 | Physical (extended) address |

## Verification
A corrupted page register shows up as a wrong upper part of `phys_o` on the first window access after the corruption. It is visible in that same cycle, because the decode is combinational. A corrupted base register moves a region's boundaries. The next access near a boundary, or into a newly overlapping area, then raises the wrong `sel_o` bit. The bench therefore probes region edges and deliberate overlaps, and re-reads windows after writes that must and must not take effect.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int NSEL   = 10;
  localparam int NWIN   = 3;
  localparam int NRGN   = 4;
  localparam int S_REG  = 0;
  localparam int S_VEC  = 1;
  localparam int S_DROM = 2;
  localparam int S_DREG = 3;
  localparam int S_RAM  = 4;
  localparam int S_EE   = 5;
  localparam int S_FL   = 6;
  localparam int S_WIN0 = 7;
endpackage

// File: rtl/mmap_region_match.sv
module mmap_region_match #(
  parameter int AW   = 16,
  parameter int SIZE = 512
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit
);
  logic [AW:0] a_ext, lo_ext, hi_ext;

  always_comb begin
    a_ext  = {1'b0, addr};
    lo_ext = {1'b0, base};
    hi_ext = lo_ext + (AW+1)'(SIZE);
    hit    = (a_ext >= lo_ext) && (a_ext < hi_ext);
  end
endmodule

// File: rtl/mmap_window.sv
module mmap_window #(
  parameter int            AW    = 16,
  parameter int            PW    = 8,
  parameter int            XW    = 22,
  parameter int            OBITS = 14,
  parameter logic [AW-1:0] BASE  = 16'h8000
) (
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] page,
  output logic          hit,
  output logic [XW-1:0] xaddr
);
  always_comb begin
    hit   = (addr[AW-1:OBITS] == BASE[AW-1:OBITS]);
    xaddr = XW'({page, addr[OBITS-1:0]});
  end
endmodule

// File: rtl/mmap_cfg.sv
module mmap_cfg #(
  parameter int                 DW       = 8,
  parameter int                 OFFW     = 9,
  parameter int                 NWIN     = 3,
  parameter int                 NRGN     = 4,
  parameter logic [OFFW-1:0]    PG_OFF   = 9'h010,
  parameter logic [OFFW-1:0]    BASE_OFF = 9'h018,
  parameter logic [NRGN*DW-1:0] RST_BASE = 32'hC0_10_08_00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [OFFW-1:0]           wr_off,
  input  logic [DW-1:0]             wdata,
  output logic [NWIN-1:0][DW-1:0]   page_o,
  output logic [NRGN-1:0][DW-1:0]   base_o
);
  logic [NWIN-1:0] pg_ld;
  logic [NRGN-1:0] bs_ld;

  always_comb begin
    for (int i = 0; i < NWIN; i++)
      pg_ld[i] = wr_en && (wr_off == PG_OFF + OFFW'(i));
    for (int j = 0; j < NRGN; j++)
      bs_ld[j] = wr_en && (wr_off == BASE_OFF + OFFW'(j));
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_pg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        page_o[g] <= '0;
      else if (pg_ld[g]) page_o[g] <= wdata;
    end
  end

  for (genvar r = 0; r < NRGN; r++) begin : g_bs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        base_o[r] <= RST_BASE[r*DW +: DW];
      else if (bs_ld[r]) base_o[r] <= wdata;
    end
  end
endmodule

// File: rtl/mmap_prio.sv
module mmap_prio #(
  parameter int N = 10
) (
  input  logic         valid,
  input  logic [N-1:0] req,
  output logic [N-1:0] sel,
  output logic         none
);
  logic found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        sel[i] = valid;
        found  = 1'b1;
      end
    end
    none = valid && !found;
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter int            XW       = 22,
  parameter int            REG_SIZE = 512,
  parameter int            RAM_SIZE = 1024,
  parameter int            EE_SIZE  = 768,
  parameter int            FL_SIZE  = 16384,
  parameter logic [AW-1:0] PWIN_BASE = 16'h8000,
  parameter int            PWIN_BITS = 14,
  parameter logic [AW-1:0] DWIN_BASE = 16'h7000,
  parameter int            DWIN_BITS = 12,
  parameter logic [AW-1:0] XWIN_BASE = 16'h0400,
  parameter int            XWIN_BITS = 10,
  parameter logic [AW-1:0] VEC_LO  = 16'hFFC0,
  parameter logic [AW-1:0] DROM_LO = 16'hFF20,
  parameter logic [AW-1:0] DREG_LO = 16'hFF00,
  parameter logic [AW-1:0] DREG_HI = 16'hFF06,
  parameter logic [4*DW-1:0] RST_BASE = 32'hC0_10_08_00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  logic            cpu_wr,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic            dbg_active,
  output logic [NSEL-1:0] sel_o,
  output logic            ext_o,
  output logic [XW-1:0]   phys_o
);
  localparam int OFFW = $clog2(REG_SIZE);
  localparam int LOWB = AW - DW;
  localparam int RGN_SIZE [NRGN] = '{REG_SIZE, RAM_SIZE, EE_SIZE, FL_SIZE};
  localparam int RGN_SLOT [NRGN] = '{S_REG, S_RAM, S_EE, S_FL};
  localparam logic [AW-1:0] WIN_BASE [NWIN] = '{PWIN_BASE, DWIN_BASE, XWIN_BASE};
  localparam int WIN_BITS [NWIN] = '{PWIN_BITS, DWIN_BITS, XWIN_BITS};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  logic [NWIN-1:0][DW-1:0] page_q;
  logic [NRGN-1:0][DW-1:0] base_q;
  logic [NRGN-1:0][AW-1:0] base16;
  logic [NSEL-1:0]         req;
  logic [NSEL-1:0]         sel;
  logic                    none;
  logic [NWIN-1:0]         win_hit;
  logic [NWIN-1:0][XW-1:0] win_x;
  logic                    wr_en;
  logic [OFFW-1:0]         wr_off;

  // relocatable on-chip regions
  for (genvar r = 0; r < NRGN; r++) begin : g_rgn
    logic hit;
    assign base16[r] = {base_q[r], {LOWB{1'b0}}};
    mmap_region_match #(.AW(AW), .SIZE(RGN_SIZE[r])) u_match (
      .addr (cpu_addr),
      .base (base16[r]),
      .hit  (hit)
    );
    assign req[RGN_SLOT[r]] = hit;
  end

  // paging windows
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    mmap_window #(
      .AW(AW), .PW(DW), .XW(XW), .OBITS(WIN_BITS[w]), .BASE(WIN_BASE[w])
    ) u_win (
      .addr  (cpu_addr),
      .page  (page_q[w]),
      .hit   (win_hit[w]),
      .xaddr (win_x[w])
    );
    assign req[S_WIN0 + w] = win_hit[w];
  end

  // vectors and debug overlay
  always_comb begin
    req[S_VEC]  = !dbg_active && (cpu_addr >= VEC_LO);
    req[S_DROM] =  dbg_active && (cpu_addr >= DROM_LO);
    req[S_DREG] =  dbg_active && (cpu_addr >= DREG_LO) && (cpu_addr <= DREG_HI);
  end

  mmap_prio #(.N(NSEL)) u_prio (
    .valid (cpu_valid),
    .req   (req),
    .sel   (sel),
    .none  (none)
  );

  // configuration writes land only when the register block wins
  always_comb begin
    wr_en  = sel[S_REG] && cpu_wr;
    wr_off = cpu_addr[OFFW-1:0] - base16[0][OFFW-1:0];
  end

  mmap_cfg #(
    .DW(DW), .OFFW(OFFW), .NWIN(NWIN), .NRGN(NRGN),
    .PG_OFF(OFFW'(16'h010)), .BASE_OFF(OFFW'(16'h018)), .RST_BASE(RST_BASE)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_en  (wr_en),
    .wr_off (wr_off),
    .wdata  (cpu_wdata),
    .page_o (page_q),
    .base_o (base_q)
  );

  always_comb begin
    phys_o = XW'(cpu_addr);
    for (int w = 0; w < NWIN; w++)
      if (sel[S_WIN0 + w]) phys_o = win_x[w];
    sel_o = sel;
    ext_o = none;
  end
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk
  import mmap_pkg::*;
#(
  parameter int AW = 16,
  parameter int XW = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_valid,
  input logic            cpu_wr,
  input logic [AW-1:0]   cpu_addr,
  input logic            dbg_active,
  input logic [NSEL-1:0] sel_o,
  input logic            ext_o,
  input logic [XW-1:0]   phys_o
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_o, sel_o}));

  a_r1_one_per_access: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> ($countones({ext_o, sel_o}) == 1));

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> ({ext_o, sel_o} == '0));

  a_r5_unpaged: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr[AW-1:AW-2] == 2'b11)
      |-> (sel_o[S_WIN0 +: NWIN] == '0) && (phys_o == XW'(cpu_addr)));

  a_r7_dbg_absent: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_active |-> (!sel_o[S_DROM] && !sel_o[S_DREG]));

  a_r6_drom_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && dbg_active && cpu_addr >= 16'hFF20 && !sel_o[S_REG])
      |-> sel_o[S_DROM]);

  a_r9_ext_phys: assert property (@(posedge clk) disable iff (!rst_n)
    ext_o |-> (phys_o == XW'(cpu_addr)));

  a_r4_page_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && sel_o[S_WIN0] && $past(cpu_valid && !cpu_wr && sel_o[S_WIN0])
      && $stable(cpu_addr)) |-> $stable(phys_o));
endmodule

bind mmap_decoder mmap_decoder_chk #(.AW(AW), .XW(XW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_valid  (cpu_valid),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .dbg_active (dbg_active),
  .sel_o      (sel_o),
  .ext_o      (ext_o),
  .phys_o     (phys_o)
);

// File: tb/mmap_decoder_bench.sv
`timescale 1ns/1ps
module mmap_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_wr, dbg_active;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [9:0]  sel_o;
  logic        ext_o;
  logic [21:0] phys_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_page [3];
  logic [7:0] m_base [4];
  int         m_size [4] = '{512, 1024, 768, 16384};

  always #5 clk = ~clk;

  mmap_decoder u_mmap_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .dbg_active(dbg_active),
    .sel_o(sel_o), .ext_o(ext_o), .phys_o(phys_o)
  );

  function automatic bit in_rgn(input logic [15:0] a, input int r);
    int lo = int'({m_base[r], 8'h00});
    return (int'(a) >= lo) && (int'(a) < lo + m_size[r]);
  endfunction

  // 0..9 = sel bit, 10 = external
  function automatic int exp_idx(input logic [15:0] a, input bit dbg);
    if (in_rgn(a, 0))                          return 0;
    if (!dbg && a >= 16'hFFC0)                 return 1;
    if (dbg && a >= 16'hFF20)                  return 2;
    if (dbg && a >= 16'hFF00 && a <= 16'hFF06) return 3;
    if (in_rgn(a, 1))                          return 4;
    if (in_rgn(a, 2))                          return 5;
    if (in_rgn(a, 3))                          return 6;
    if (a[15:14] == 2'b10)                     return 7;
    if (a[15:12] == 4'h7)                      return 8;
    if (a[15:10] == 6'b000001)                 return 9;
    return 10;
  endfunction

  function automatic logic [21:0] exp_phys(input int idx, input logic [15:0] a);
    case (idx)
      7:       return {m_page[0], a[13:0]};
      8:       return {2'b0, m_page[1], a[11:0]};
      9:       return {4'b0, m_page[2], a[9:0]};
      default: return {6'b0, a};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input bit wr, input logic [7:0] d,
                     input bit dbg, input string tag);
    int idx;
    logic [15:0] off;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; dbg_active = dbg;
    #2;
    idx = exp_idx(a, dbg);
    check({tag, " sel"}, {21'b0, ext_o, sel_o}, 32'(11'(1) << idx));
    check({tag, " phys"}, {10'b0, phys_o}, {10'b0, exp_phys(idx, a)});
    @(posedge clk);
    #1;
    if (wr && idx == 0) begin
      off = a - {m_base[0], 8'h00};
      if (off >= 16'h10 && off <= 16'h12) m_page[off - 16'h10] = d;
      if (off >= 16'h18 && off <= 16'h1B) m_base[off - 16'h18] = d;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_page = '{8'h00, 8'h00, 8'h00};
    m_base = '{8'h00, 8'h08, 8'h10, 8'hC0};
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_wr = 1'b0; cpu_addr = '0;
    cpu_wdata = '0; dbg_active = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 idle during reset", {21'b0, ext_o, sel_o}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1 idle after reset", {21'b0, ext_o, sel_o}, 32'h0);

    // R8 default bases and sizes, R9 unmatched goes external
    acc(16'h0000, 0, 0, 0, "R8 regs default");
    acc(16'h01FF, 0, 0, 0, "R8 regs top");
    acc(16'h0200, 0, 0, 0, "R9 gap external");
    acc(16'h0800, 0, 0, 0, "R8 ram default");
    acc(16'h1000, 0, 0, 0, "R8 eeprom default");
    acc(16'h12FF, 0, 0, 0, "R8 eeprom top");
    acc(16'h1300, 0, 0, 0, "R9 after eeprom");
    acc(16'hC000, 0, 0, 0, "R8 flash default");

    // R4 reset pages and page writes, R3 window placement
    acc(16'h8123, 0, 0, 0, "R4 prog page reset zero");
    acc(16'h0010, 1, 8'h5A, 0, "R4 write prog page");
    acc(16'h8123, 0, 0, 0, "R3 prog window phys");
    acc(16'hBFFF, 0, 0, 0, "R3 prog window top");
    acc(16'h0011, 1, 8'hA5, 0, "R4 write data page");
    acc(16'h7ABC, 0, 0, 0, "R3 data window phys");
    acc(16'h0012, 1, 8'h3C, 0, "R4 write extra page");
    acc(16'h05FF, 0, 0, 0, "R3 extra window phys");

    // R5 unpaged top quarter, R7 vectors without debug
    acc(16'hC123, 0, 0, 0, "R5 unpaged flash");
    acc(16'hFFFE, 0, 0, 0, "R7 vector area");
    acc(16'hFF00, 0, 0, 0, "R7 debug regs absent");
    acc(16'hFF20, 0, 0, 0, "R7 debug rom absent");

    // R6 debug overlay
    acc(16'hFF20, 0, 0, 1, "R6 debug rom low");
    acc(16'hFFFE, 0, 0, 1, "R6 debug rom replaces vectors");
    acc(16'hFF00, 0, 0, 1, "R6 debug regs low");
    acc(16'hFF06, 0, 0, 1, "R6 debug regs high");
    acc(16'hFF07, 0, 0, 1, "R6 gap decodes to flash");

    // R2 precedence via relocation
    acc(16'h0019, 1, 8'h00, 0, "R8 move ram to 0000");
    acc(16'h0000, 0, 0, 0, "R2 regs over ram");
    acc(16'h0200, 0, 0, 0, "R2 ram visible");
    acc(16'h001A, 1, 8'h02, 0, "R8 move eeprom to 0200");
    acc(16'h0200, 0, 0, 0, "R2 ram over eeprom");
    acc(16'h0450, 0, 0, 0, "R2 eeprom over extra window");
    acc(16'h001B, 1, 8'h80, 0, "R8 move flash to 8000");
    acc(16'h8000, 0, 0, 0, "R2 flash over prog window");
    acc(16'h001B, 1, 8'hC0, 0, "R8 flash back");
    acc(16'h0018, 1, 8'hFF, 0, "R8 move regs to FF00");
    acc(16'hFF20, 0, 0, 1, "R2 regs over debug rom");
    acc(16'hFFC0, 0, 0, 0, "R2 regs over vectors");
    acc(16'h0010, 1, 8'h77, 0, "R10 write to ram ignored");
    acc(16'h8123, 0, 0, 0, "R10 prog page unchanged");
    acc(16'hFF18, 1, 8'h00, 0, "R8 regs back home");
    acc(16'h0010, 0, 0, 0, "R8 regs home again");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      bit          w, dbg;
      int          pick;
      d    = 8'($urandom);
      dbg  = ($urandom % 4) == 0;
      pick = $urandom % 8;
      if (pick == 0) begin
        a = {m_base[0], 8'h00} + 16'(16'h10 + ($urandom % 3));
        w = 1'b1;
      end else if (pick == 1 && ($urandom % 4) == 0) begin
        a = {m_base[0], 8'h00} + 16'(16'h18 + ($urandom % 4));
        w = 1'b1;
      end else begin
        a = 16'($urandom);
        w = ($urandom % 10) == 0;
      end
      acc(a, w, d, dbg, "R1 R2 R3 random");
    end

    @(negedge clk) cpu_valid = 1'b0;
    #2;
    check("R1 idle at end", {21'b0, ext_o, sel_o}, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule